// File: doc/BRIEF.md
# Operand-2 Barrel Shifter with Shifter Carry

This block forms the second ALU operand for a 32-bit processor's data-processing instructions. It is purely combinational. It reads the fields of the instruction word it needs, the value of the shifted source register, the low byte of the shift-amount register, and the current carry flag. It returns the shifted operand together with a shifter carry-out, which the logical flag-setting instructions write into C.

The operand comes from one of three sources. The first is an 8-bit immediate rotated right by an even amount. The second is the source register shifted by a 5-bit amount held in the instruction. The third is the source register shifted by a register-supplied amount. Several zero encodings carry special meanings, and the carry rules change at amounts of 0, 32 and above 32.

Register fetch, the ALU and the flag write-back sit around the block and are not part of it.

Top module: `opsh_operand2`

## Requirements
- R1: When instruction bit 25 is 1, the operand is instruction bits 7:0, zero-extended and rotated right by twice the value in bits 11:8.
- R2: For the rotated immediate, the carry-out equals the incoming carry when bits 11:8 are zero. Otherwise it equals bit 31 of the operand.
- R3: When bit 25 is 0, bits 6:5 select the shift: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. Bit 4 = 0 takes the amount from bits 11:7. Bit 4 = 1 takes it from the register low byte, and bits 11:7 are then ignored.
- R4: An immediate left shift of 0 passes the register through with carry-out equal to the incoming carry. A left shift of n (1..31) gives the register shifted left by n with carry-out equal to register bit 32-n.
- R5: An immediate right shift, arithmetic shift or rotate by n (1..31) gives the shifted or rotated register with carry-out equal to register bit n-1.
- R6: An immediate logical right shift of 0 acts as a shift by 32: the operand is 0 and the carry-out is register bit 31.
- R7: An immediate arithmetic right shift of 0 acts as a shift by 32: every operand bit and the carry-out equal register bit 31.
- R8: An immediate rotate of 0 is a one-bit rotate through carry: the operand is {carry, register[31:1]} and the carry-out is register bit 0.
- R9: A register-specified amount of 0 passes the register through with carry-out equal to the incoming carry, for all four shift types.
- R10: A register left shift or logical right shift by exactly 32 gives operand 0, with carry-out equal to register bit 0 (left) or register bit 31 (right). By more than 32, both the operand and the carry-out are 0.
- R11: A register arithmetic right shift by 32 or more fills every operand bit with register bit 31, and the carry-out is register bit 31.
- R12: A register rotate uses the amount modulo 32. A nonzero multiple of 32 returns the register unchanged with carry-out equal to register bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Instruction word; bits 25 and 11:0 are decoded |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_low | input | 8 | Low byte of the shift-amount register |
| c_flag | input | 1 | Current carry flag |
| op2 | output | 32 | Shifted or rotated operand |
| shift_carry | output | 1 | Shifter carry-out |

## Verification
The hardest cases to reach are the register-specified amounts at and beyond the word width. Exactly 32, 33, nonzero multiples of 32 for the rotate, and 255 each take a different carry rule. Uniformly random register bytes rarely hit exactly 32 or 64. The stimulus therefore places directed cases on each of those amounts for every shift type. The random phase draws the amount from a mix that is weighted toward 0, 31, 32, 33 and multiples of 32. Each expected value comes from a bit-at-a-time serial shift model in the bench.

// File: rtl/opsh_pkg.sv
// Package: shared constants and types for the operand-2 shifter.
// Assumes a 32-bit datapath whose immediate shift field is log2(word) bits wide.
package opsh_pkg;

    localparam int WORD_W  = 32;
    localparam int SA_W    = $clog2(WORD_W);
    localparam int RSAMT_W = 8;
    localparam int ROT_W   = 4;
    localparam int IMM_W   = 8;

    // Shift type as encoded in the instruction (order is decoded behaviour)
    typedef enum logic [1:0] {
        ST_LSL = 2'b00,
        ST_LSR = 2'b01,
        ST_ASR = 2'b10,
        ST_ROR = 2'b11
    } stype_e;

    // Normalised operation handed from the decoder to the engine
    typedef enum logic [2:0] {
        SK_PASS = 3'd0,
        SK_LSL  = 3'd1,
        SK_LSR  = 3'd2,
        SK_ASR  = 3'd3,
        SK_ROR  = 3'd4,
        SK_RRX  = 3'd5
    } shkind_e;

    // amt: amount modulo the word width; sat: amount >= width; beyond: amount > width
    typedef struct packed {
        shkind_e         kind;
        logic [SA_W-1:0] amt;
        logic            sat;
        logic            beyond;
    } shctl_t;

endpackage

// File: rtl/opsh_rotr.sv
// Module: opsh_rotr
// Logarithmic right rotator: one mux stage per bit of the rotate amount.
// Assumes W is a power of two so the amount wraps naturally modulo W.
module opsh_rotr #(
    parameter int W    = opsh_pkg::WORD_W,
    parameter int SA_W = $clog2(W)
) (
    input  logic [W-1:0]    din,
    input  logic [SA_W-1:0] amt,
    output logic [W-1:0]    dout
);

    logic [W-1:0] stage [0:SA_W];

    assign stage[0] = din;

    // Each stage rotates right by 2**k when amount bit k is set
    for (genvar k = 0; k < SA_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k] ? {stage[k][STEP-1:0], stage[k][W-1:STEP]}
                                   : stage[k];
    end

    assign dout = stage[SA_W];

endmodule

// File: rtl/opsh_decode.sv
// Module: opsh_decode
// Turns the instruction's operand-2 fields and the register amount into a
// normalised shift command, folding every zero-amount special case.
// Assumes the immediate shift field is exactly SA_W bits wide.
module opsh_decode
    import opsh_pkg::*;
(
    input  logic               imm_form,
    input  logic [ROT_W-1:0]   rot_field,
    input  logic [SA_W-1:0]    shamt_field,
    input  logic [1:0]         stype,
    input  logic               reg_form,
    input  logic [RSAMT_W-1:0] rs_amt,
    output shctl_t             ctl
);

    localparam int HI_W = RSAMT_W - SA_W;

    logic [HI_W-1:0] rs_hi;
    logic            rs_sat;
    logic            rs_beyond;

    // Map the encoded shift type onto the engine's operation set
    function automatic shkind_e kind_of(input logic [1:0] t);
        case (stype_e'(t))
            ST_LSL:  return SK_LSL;
            ST_LSR:  return SK_LSR;
            ST_ASR:  return SK_ASR;
            default: return SK_ROR;
        endcase
    endfunction

    assign rs_hi     = rs_amt[RSAMT_W-1:SA_W];
    assign rs_sat    = |rs_hi;
    assign rs_beyond = rs_sat && ((rs_amt[SA_W-1:0] != '0) || (rs_hi != HI_W'(1)));

    // Select the command for the rotated-immediate, immediate-shift or register-shift form
    always_comb begin
        ctl = '{kind: SK_PASS, amt: '0, sat: 1'b0, beyond: 1'b0};
        if (imm_form) begin
            if (rot_field != '0) begin
                ctl.kind = SK_ROR;
                ctl.amt  = SA_W'({rot_field, 1'b0});
            end
        end else if (reg_form) begin
            if (rs_amt != '0) begin
                ctl.kind   = kind_of(stype);
                ctl.amt    = rs_amt[SA_W-1:0];
                ctl.sat    = rs_sat;
                ctl.beyond = rs_beyond;
            end
        end else if (shamt_field != '0) begin
            ctl.kind = kind_of(stype);
            ctl.amt  = shamt_field;
        end else begin
            case (stype_e'(stype))
                ST_LSL: ctl.kind = SK_PASS;
                ST_LSR: begin
                    ctl.kind = SK_LSR;
                    ctl.sat  = 1'b1;
                end
                ST_ASR: begin
                    ctl.kind = SK_ASR;
                    ctl.sat  = 1'b1;
                end
                default: ctl.kind = SK_RRX;
            endcase
        end
    end

endmodule

// File: rtl/opsh_engine.sv
// Module: opsh_engine
// Executes a normalised shift command on one shared right rotator. Shifts are
// built as rotate plus keep-mask plus fill; the carry is read from the rotated word.
// Assumes the command came from opsh_decode (amt is the amount modulo W).
module opsh_engine
    import opsh_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] src,
    input  logic         c_in,
    input  shctl_t       ctl,
    output logic [W-1:0] res,
    output logic         c_out
);

    localparam logic [W-1:0] ONES = '1;

    logic [SA_W-1:0] rot_amt;
    logic [W-1:0]    rot;
    logic [W-1:0]    keep;
    logic [W-1:0]    fill;

    // A left shift by n is a right rotate by W-n
    always_comb begin
        if (ctl.kind == SK_LSL) rot_amt = '0 - ctl.amt;
        else                    rot_amt = ctl.amt;
    end

    opsh_rotr #(.W(W), .SA_W(SA_W)) rotr_i (
        .din  (src),
        .amt  (rot_amt),
        .dout (rot)
    );

    // Mark which rotated bits survive the shift
    always_comb begin
        case (ctl.kind)
            SK_LSL:         keep = ctl.sat ? '0 : (ONES << ctl.amt);
            SK_LSR, SK_ASR: keep = ctl.sat ? '0 : (ONES >> ctl.amt);
            default:        keep = ONES;
        endcase
    end

    // Vacated positions take the sign for arithmetic shifts, zero otherwise
    assign fill = (ctl.kind == SK_ASR) ? {W{src[W-1]}} : '0;

    // Assemble the operand
    always_comb begin
        case (ctl.kind)
            SK_PASS: res = src;
            SK_RRX:  res = {c_in, src[W-1:1]};
            default: res = (rot & keep) | (fill & ~keep);
        endcase
    end

    // Pick the last bit shifted out, or the rule for the boundary amounts
    always_comb begin
        case (ctl.kind)
            SK_PASS: c_out = c_in;
            SK_RRX:  c_out = src[0];
            SK_LSL:  c_out = ctl.beyond ? 1'b0 : rot[0];
            SK_LSR:  c_out = ctl.beyond ? 1'b0 : rot[W-1];
            SK_ASR:  c_out = ctl.sat ? src[W-1] : rot[W-1];
            default: c_out = rot[W-1];
        endcase
    end

endmodule

// File: rtl/opsh_operand2.sv
// Module: opsh_operand2 (top)
// Combinational operand-2 generator: rotated immediate or shifted register,
// with shifter carry-out. Instruction bits outside 25 and 11:0 are not used.
module opsh_operand2
    import opsh_pkg::*;
(
    input  logic [WORD_W-1:0]  instr_word,
    input  logic [WORD_W-1:0]  rm_val,
    input  logic [RSAMT_W-1:0] rs_low,
    input  logic               c_flag,
    output logic [WORD_W-1:0]  op2,
    output logic               shift_carry
);

    logic              imm_form;
    logic [WORD_W-1:0] src;
    shctl_t            ctl;
    logic              unused_fields;

    assign imm_form      = instr_word[25];
    assign unused_fields = ^{instr_word[31:26], instr_word[24:12]};

    // Source word: zero-extended immediate or the register value
    assign src = imm_form ? WORD_W'(instr_word[IMM_W-1:0]) : rm_val;

    opsh_decode dec_i (
        .imm_form    (imm_form),
        .rot_field   (instr_word[11:8]),
        .shamt_field (instr_word[11:7]),
        .stype       (instr_word[6:5]),
        .reg_form    (instr_word[4]),
        .rs_amt      (rs_low),
        .ctl         (ctl)
    );

    opsh_engine #(.W(WORD_W)) eng_i (
        .src   (src),
        .c_in  (c_flag),
        .ctl   (ctl),
        .res   (op2),
        .c_out (shift_carry)
    );

endmodule

// File: rtl/opsh_operand2_chk.sv
// Module: opsh_operand2_chk
// Port-level checks of the boundary encodings, bound to opsh_operand2.
// Checks are skipped while any input is unknown.
module opsh_operand2_chk
    import opsh_pkg::*;
(
    input logic [WORD_W-1:0]  instr_word,
    input logic [WORD_W-1:0]  rm_val,
    input logic [RSAMT_W-1:0] rs_low,
    input logic               c_flag,
    input logic [WORD_W-1:0]  op2,
    input logic               shift_carry
);

    logic       is_imm, is_ishift, is_rshift;
    logic [1:0] ty;
    logic       known;

    assign is_imm    = instr_word[25];
    assign is_ishift = !instr_word[25] && !instr_word[4];
    assign is_rshift = !instr_word[25] && instr_word[4];
    assign ty        = instr_word[6:5];
    assign known     = !$isunknown({instr_word, rm_val, rs_low, c_flag, op2, shift_carry});

    // Compare outputs against the special-case rules
    always_comb begin
        if (known) begin
            if (is_imm && instr_word[11:8] == 4'd0)
                a_r1_imm_norot: assert (op2 == WORD_W'(instr_word[7:0]) && shift_carry == c_flag)
                    else $error("a_r1_imm_norot");
            if (is_imm && instr_word[11:8] != 4'd0)
                a_r2_imm_carry: assert (shift_carry == op2[WORD_W-1])
                    else $error("a_r2_imm_carry");
            if (is_ishift && ty == 2'b00 && instr_word[11:7] == 5'd0)
                a_r4_lsl_zero: assert (op2 == rm_val && shift_carry == c_flag)
                    else $error("a_r4_lsl_zero");
            if (is_ishift && ty == 2'b01 && instr_word[11:7] == 5'd0)
                a_r6_lsr_full: assert (op2 == '0 && shift_carry == rm_val[WORD_W-1])
                    else $error("a_r6_lsr_full");
            if (is_ishift && ty == 2'b10 && instr_word[11:7] == 5'd0)
                a_r7_asr_full: assert (op2 == {WORD_W{rm_val[WORD_W-1]}} && shift_carry == rm_val[WORD_W-1])
                    else $error("a_r7_asr_full");
            if (is_ishift && ty == 2'b11 && instr_word[11:7] == 5'd0)
                a_r8_rrx: assert (op2 == {c_flag, rm_val[WORD_W-1:1]} && shift_carry == rm_val[0])
                    else $error("a_r8_rrx");
            if (is_rshift && rs_low == '0)
                a_r9_reg_zero: assert (op2 == rm_val && shift_carry == c_flag)
                    else $error("a_r9_reg_zero");
            if (is_rshift && !ty[1] && rs_low > 8'd32)
                a_r10_reg_far: assert (op2 == '0 && !shift_carry)
                    else $error("a_r10_reg_far");
            if (is_rshift && ty == 2'b10 && rs_low >= 8'd32)
                a_r11_asr_far: assert (op2 == {WORD_W{rm_val[WORD_W-1]}} && shift_carry == rm_val[WORD_W-1])
                    else $error("a_r11_asr_far");
            if (is_rshift && ty == 2'b11 && rs_low != '0 && rs_low[4:0] == 5'd0)
                a_r12_ror_wrap: assert (op2 == rm_val && shift_carry == rm_val[WORD_W-1])
                    else $error("a_r12_ror_wrap");
        end
    end

endmodule

bind opsh_operand2 opsh_operand2_chk chk_i (.*);

// File: tb/opsh_operand2_tb_top.sv
// Bench: scoreboard for opsh_operand2. A driver task computes the expected
// result with a serial bit-at-a-time model and queues it; a monitor compares.
module opsh_operand2_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] rm_val = '0;
    logic [7:0]  rs_low = '0;
    logic        c_flag = 1'b0;
    logic [31:0] op2;
    logic        shift_carry;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp_op;
        logic        exp_c;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    opsh_operand2 dut_i (
        .instr_word  (instr_word),
        .rm_val      (rm_val),
        .rs_low      (rs_low),
        .c_flag      (c_flag),
        .op2         (op2),
        .shift_carry (shift_carry)
    );

    // Serial reference: shift one position per step
    function automatic void ref_model(input logic [31:0] ins, input logic [31:0] rmv,
                                      input logic [7:0] rsv, input logic cv,
                                      output logic [31:0] r, output logic co);
        logic [31:0] v;
        int amt;
        co = cv;
        if (ins[25]) begin
            v = {24'd0, ins[7:0]};
            for (int i = 0; i < 2 * int'(ins[11:8]); i++) v = {v[0], v[31:1]};
            if (ins[11:8] != 0) co = v[31];
            r = v;
            return;
        end
        v = rmv;
        amt = ins[4] ? int'(rsv) : int'(ins[11:7]);
        if (!ins[4] && amt == 0) begin
            case (ins[6:5])
                2'b00: begin r = rmv; co = cv; end
                2'b01: begin r = '0; co = rmv[31]; end
                2'b10: begin r = {32{rmv[31]}}; co = rmv[31]; end
                default: begin r = {cv, rmv[31:1]}; co = rmv[0]; end
            endcase
            return;
        end
        for (int i = 0; i < amt; i++) begin
            case (ins[6:5])
                2'b00: begin co = v[31]; v = {v[30:0], 1'b0}; end
                2'b01: begin co = v[0]; v = {1'b0, v[31:1]}; end
                2'b10: begin co = v[0]; v = {v[31], v[31:1]}; end
                default: begin co = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        r = v;
    endfunction

    // Driver: apply one stimulus and queue its expected result
    task automatic drive(input logic [31:0] ins, input logic [31:0] rmv,
                         input logic [7:0] rsv, input logic cv, input string tag);
        item_t it;
        ref_model(ins, rmv, rsv, cv, it.exp_op, it.exp_c);
        it.tag = tag;
        @(negedge clk);
        instr_word = ins;
        rm_val     = rmv;
        rs_low     = rsv;
        c_flag     = cv;
        sb_q.push_back(it);
    endtask

    // Directly checked value with a fixed expectation
    task automatic check_fixed(input logic [31:0] eop, input logic ec, input string tag);
        checks++;
        if (op2 !== eop || shift_carry !== ec) begin
            failures++;
            $display("FAIL %s: op2=%h carry=%b expected op2=%h carry=%b", tag, op2, shift_carry, eop, ec);
        end
    endtask

    function automatic logic [31:0] f_imm(input int rot, input logic [7:0] imm);
        return 32'h0200_0000 | (32'(rot) << 8) | {24'd0, imm};
    endfunction

    function automatic logic [31:0] f_ish(input int sh, input int ty);
        return (32'(sh) << 7) | (32'(ty) << 5);
    endfunction

    function automatic logic [31:0] f_rsh(input int ty);
        return 32'h0000_0F80 | (32'(ty) << 5) | 32'h10;
    endfunction

    // Monitor: compare at the rising edge, half a period after the drive
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (op2 !== it.exp_op || shift_carry !== it.exp_c) begin
                failures++;
                $display("FAIL %s: op2=%h carry=%b expected op2=%h carry=%b",
                         it.tag, op2, shift_carry, it.exp_op, it.exp_c);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_fixed(32'h0, 1'b0, "R4 reset state");
        rst_n = 1'b1;

        drive(f_imm(0, 8'hAB), 32'hFFFF_FFFF, 8'h00, 1'b1, "R1 R2 imm no rotate");
        drive(f_imm(1, 8'hFF), 32'h0, 8'h00, 1'b0, "R1 R2 imm rotate 2");
        drive(f_imm(4, 8'h12), 32'h0, 8'h00, 1'b1, "R1 R2 imm rotate 8");
        drive(f_imm(15, 8'h81), 32'h0, 8'h00, 1'b0, "R1 imm rotate 30");
        drive(f_ish(0, 0), 32'h8000_0001, 8'h00, 1'b1, "R4 LSL 0");
        drive(f_ish(4, 0), 32'hF000_0000, 8'h00, 1'b0, "R4 LSL 4");
        drive(f_ish(1, 0), 32'h4000_0000, 8'h00, 1'b1, "R4 LSL 1");
        drive(f_ish(31, 0), 32'h0000_0003, 8'h00, 1'b0, "R4 LSL 31");
        drive(f_ish(4, 1), 32'h0000_0018, 8'h00, 1'b0, "R5 LSR 4");
        drive(f_ish(4, 2), 32'h8000_0000, 8'h00, 1'b1, "R5 ASR 4");
        drive(f_ish(8, 3), 32'h1234_5678, 8'h00, 1'b1, "R5 ROR 8");
        drive(f_ish(0, 1), 32'h8000_0000, 8'h00, 1'b0, "R6 LSR 0");
        drive(f_ish(0, 2), 32'h8000_0000, 8'h00, 1'b0, "R7 ASR 0 neg");
        drive(f_ish(0, 2), 32'h7FFF_FFFF, 8'h00, 1'b1, "R7 ASR 0 pos");
        drive(f_ish(0, 3), 32'h0000_0003, 8'h00, 1'b1, "R8 RRX");
        drive(f_ish(0, 3), 32'hFFFF_FFFE, 8'h00, 1'b0, "R8 RRX c0");
        drive(f_rsh(0), 32'h0000_1234, 8'd0, 1'b1, "R9 reg LSL 0");
        drive(f_rsh(3), 32'h8000_0000, 8'd0, 1'b0, "R9 reg ROR 0");
        drive(f_rsh(1), 32'h8000_0001, 8'd0, 1'b1, "R9 reg LSR 0");
        drive(f_rsh(0), 32'h0000_0001, 8'd4, 1'b0, "R3 reg LSL 4 ignores 11:7");
        drive(f_rsh(0), 32'h0000_0001, 8'd32, 1'b0, "R10 reg LSL 32");
        drive(f_rsh(1), 32'h8000_0000, 8'd32, 1'b0, "R10 reg LSR 32");
        drive(f_rsh(0), 32'hFFFF_FFFF, 8'd33, 1'b1, "R10 reg LSL 33");
        drive(f_rsh(1), 32'hFFFF_FFFF, 8'd200, 1'b1, "R10 reg LSR 200");
        drive(f_rsh(2), 32'h8000_0000, 8'd32, 1'b0, "R11 reg ASR 32");
        drive(f_rsh(2), 32'h4000_0000, 8'd255, 1'b1, "R11 reg ASR 255");
        drive(f_rsh(3), 32'h8000_0001, 8'd32, 1'b0, "R12 reg ROR 32");
        drive(f_rsh(3), 32'h0000_00F0, 8'd36, 1'b1, "R12 reg ROR 36");
        drive(f_rsh(3), 32'h7FFF_FFFF, 8'd64, 1'b1, "R12 reg ROR 64");
        drive(f_rsh(2), 32'h8000_0100, 8'd9, 1'b0, "R5 reg ASR 9");

        for (int n = 0; n < 600; n++) begin
            logic [31:0] ins;
            logic [7:0]  rsv;
            ins = $urandom;
            case ($urandom_range(0, 7))
                0: rsv = 8'd0;
                1: rsv = 8'd31;
                2: rsv = 8'd32;
                3: rsv = 8'd33;
                4: rsv = 8'($urandom_range(1, 7) * 32);
                default: rsv = 8'($urandom);
            endcase
            drive(ins, $urandom, rsv, 1'($urandom), "R3 random mix");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule